// File: doc/BRIEF.md
# Insertion Debounce and Restart Sequencer

This block produces the first open-circuit-voltage estimate that a battery gauge model starts from. After reset is released, after a quick-start request, or after a battery swap is detected, it opens a fresh debounce window. In that window it samples the 12-bit cell-voltage code on each of 16 consecutive millisecond ticks and keeps the largest value, not an average. It then publishes that value with an OCV-ready flag. A second flag follows once the gauge model has had time to settle. Every restart also sends a one-cycle pulse toward the model and sets a sticky voltage-reset status flag.

Battery swap detection arms when the cell voltage falls below a 7-bit reset threshold and fires once it has risen back above it. The fast comparator is normally the source, and the restart follows one tick after the recovery. When the comparator is switched off in hibernate, the measured-voltage register is used instead, and the restart follows 250 ticks after the register update that reported the recovery. All delays count an external 1 ms tick and are parameters.

Top module: `debounce_restart`

## Requirements
- R1: While reset is asserted, ocv, ocv_ready, soc_ready, restart_pulse and vr_flag are all 0. On the first clock edge after reset is released, a restart takes place, and restart_pulse is high for the following cycle.
- R2: After a restart, ocv equals the largest sample seen on ticks 1 to 16. The sample present at tick 17 or later is not included.
- R3: ocv_ready rises on the 17th tick after a restart and is 0 before it. While ocv_ready is 0, ocv reads 0, and every restart clears both.
- R4: soc_ready rises on the 192nd tick after a restart, which is 175 ticks after ocv_ready. It is never high while ocv_ready is low.
- R5: A 0-to-1 transition on qs_pin causes exactly one restart. Holding the pin high, or releasing it, causes none.
- R6: A register write with qs_wr=1 and qs_data=1 causes exactly one restart two cycles later, and the bit clears itself. A write with qs_data=0 has no effect.
- R7: A restart during an open window discards that window's samples and tick count, and a full new 16-sample window starts.
- R8: With the comparator in use, cmp_above=0 arms swap detection. Once cmp_above has returned to 1, the first following tick fires a restart.
- R9: When cmp_dis=1 and hibernate=1, cmp_above is ignored. Swap detection then uses vcell on vcell_upd strobes, where a value counts as below if it is less than {rst_thr, 5'b0} (40 mV steps on the 1.25 mV code). The restart fires on the 250th tick after the update that reported the recovery. A below update during that wait re-arms detection and cancels the wait.
- R10: cmp_dis=1 while hibernate=0 has no effect, and the comparator path stays in use.
- R11: Every restart sets vr_flag, and vr_clr clears it. If a restart and vr_clr arrive together, the set wins.
- R12: restart_pulse is high for exactly one cycle per restart request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe every millisecond |
| sample | input | 12 | Current full-resolution voltage code, taken on ticks |
| qs_pin | input | 1 | External quick-start pin; acts on its rising edge |
| qs_wr | input | 1 | Write strobe of the quick-start register bit |
| qs_data | input | 1 | Value written to the quick-start bit |
| cmp_above | input | 1 | Fast comparator: 1 when the cell is above the reset threshold |
| vcell | input | 12 | Measured-voltage register value |
| vcell_upd | input | 1 | One-cycle strobe when vcell is updated |
| rst_thr | input | 7 | Reset threshold in 40 mV steps |
| cmp_dis | input | 1 | Turns off the comparator while in hibernate |
| hibernate | input | 1 | Gauge is in hibernate mode |
| vr_clr | input | 1 | Clears the voltage-reset flag |
| ocv | output | 12 | Latched initial open-circuit-voltage estimate |
| ocv_ready | output | 1 | Initial estimate is valid |
| soc_ready | output | 1 | Gauge model start-up interval has elapsed |
| restart_pulse | output | 1 | One-cycle restart toward the gauge model |
| vr_flag | output | 1 | Sticky voltage-reset status |

## Verification
The maximum search is driven with sample patterns that separate a true maximum from an average or a last-sample latch. These put the peak on the first sample, on the last sample, in the middle, at full scale, and below a rising floor. Each window ends with a full-scale value on tick 17, which exposes any off-by-one in the window length. Restarts from each source are checked by counting pulses, including a restart in the middle of a window whose earlier samples are larger. The swap path is run through the comparator path, the disable bit outside hibernate, and the register path in hibernate. The register-path runs include a value exactly at the threshold and a cancelled 250-tick wait.

// File: rtl/debounce_restart.sv
module debounce_restart #(
  parameter int VW      = 12,
  parameter int THR_W   = 7,
  parameter int SAMPLES = 16,
  parameter int SOC_MS  = 175,
  parameter int CMP_MS  = 1,
  parameter int ADC_MS  = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [VW-1:0] sample,
  input  logic          qs_pin,
  input  logic          qs_wr,
  input  logic          qs_data,
  input  logic          cmp_above,
  input  logic [VW-1:0] vcell,
  input  logic          vcell_upd,
  input  logic [THR_W-1:0] rst_thr,
  input  logic          cmp_dis,
  input  logic          hibernate,
  input  logic          vr_clr,
  output logic [VW-1:0] ocv,
  output logic          ocv_ready,
  output logic          soc_ready,
  output logic          restart_pulse,
  output logic          vr_flag
);
  localparam int OCV_MS  = SAMPLES + 1;
  localparam int DONE_MS = OCV_MS + SOC_MS;
  localparam int MSW     = $clog2(DONE_MS + 1);
  localparam int DLY_MAX = (ADC_MS > CMP_MS) ? ADC_MS : CMP_MS;
  localparam int SWW     = $clog2(DLY_MAX + 1);
  localparam int SHIFT   = VW - THR_W;

  logic           por_pend, qs_pin_q, qs_bit, swap_fire;
  logic [MSW-1:0] ms;
  logic [VW-1:0]  peak;
  logic           armed, waiting;
  logic [SWW-1:0] dcnt;

  wire req = por_pend | (qs_pin & ~qs_pin_q) | qs_bit | swap_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      por_pend      <= 1'b1;
      qs_pin_q      <= 1'b1;
      qs_bit        <= 1'b0;
      restart_pulse <= 1'b0;
      vr_flag       <= 1'b0;
    end else begin
      por_pend      <= 1'b0;
      qs_pin_q      <= qs_pin;
      qs_bit        <= qs_wr & qs_data;
      restart_pulse <= req;
      vr_flag       <= req | (vr_flag & ~vr_clr);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ms        <= '0;
      peak      <= '0;
      ocv       <= '0;
      ocv_ready <= 1'b0;
      soc_ready <= 1'b0;
    end else if (req) begin
      ms        <= '0;
      peak      <= '0;
      ocv       <= '0;
      ocv_ready <= 1'b0;
      soc_ready <= 1'b0;
    end else if (tick && !soc_ready) begin
      ms <= ms + MSW'(1);
      if (ms < MSW'(SAMPLES) && sample > peak) peak <= sample;
      if (ms == MSW'(OCV_MS - 1)) begin
        ocv       <= peak;
        ocv_ready <= 1'b1;
      end
      if (ms == MSW'(DONE_MS - 1)) soc_ready <= 1'b1;
    end

  wire          cmp_en   = ~(cmp_dis & hibernate);
  wire [VW-1:0] thr_code = {rst_thr, {SHIFT{1'b0}}};
  wire below_ev = cmp_en ? ~cmp_above : (vcell_upd & (vcell < thr_code));
  wire above_ev = cmp_en ?  cmp_above : (vcell_upd & (vcell >= thr_code));
  wire [SWW-1:0] limit = cmp_en ? SWW'(CMP_MS) : SWW'(ADC_MS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed     <= 1'b0;
      waiting   <= 1'b0;
      dcnt      <= '0;
      swap_fire <= 1'b0;
    end else begin
      swap_fire <= 1'b0;
      if (below_ev) begin
        armed   <= 1'b1;
        waiting <= 1'b0;
        dcnt    <= '0;
      end else if (armed && !waiting && above_ev) begin
        waiting <= 1'b1;
        dcnt    <= '0;
      end else if (waiting && tick) begin
        if (dcnt + SWW'(1) == limit) begin
          swap_fire <= 1'b1;
          armed     <= 1'b0;
          waiting   <= 1'b0;
          dcnt      <= '0;
        end else begin
          dcnt <= dcnt + SWW'(1);
        end
      end
    end
endmodule

module debounce_restart_chk #(parameter int VW = 12) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [VW-1:0] ocv,
  input logic          ocv_ready,
  input logic          soc_ready,
  input logic          restart_pulse,
  input logic          vr_flag
);
  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> (!ocv_ready && !soc_ready));
  assert_ocv_zero_unready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ocv_ready |-> (ocv == '0));
  assert_ready_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocv_ready) |-> $past(tick));
  assert_soc_after_ocv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soc_ready |-> ocv_ready);
  assert_ocv_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ocv_ready |=> (!ocv_ready || $stable(ocv)));
  assert_vr_on_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> vr_flag);
endmodule

bind debounce_restart debounce_restart_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ocv(ocv), .ocv_ready(ocv_ready),
  .soc_ready(soc_ready), .restart_pulse(restart_pulse), .vr_flag(vr_flag));

// File: tb/test_debounce_restart.sv
module test_debounce_restart;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [11:0] sample = '0, vcell = 12'hC00;
  logic qs_pin = 1'b0, qs_wr = 1'b0, qs_data = 1'b0, cmp_above = 1'b1;
  logic vcell_upd = 1'b0, cmp_dis = 1'b0, hibernate = 1'b0, vr_clr = 1'b0;
  logic [6:0] rst_thr = 7'd80;
  logic [11:0] ocv;
  logic ocv_ready, soc_ready, restart_pulse, vr_flag;
  int checks = 0, errors = 0, pulses = 0;

  always #10 clk = ~clk;

  debounce_restart i_debounce_restart (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample), .qs_pin(qs_pin),
    .qs_wr(qs_wr), .qs_data(qs_data), .cmp_above(cmp_above), .vcell(vcell),
    .vcell_upd(vcell_upd), .rst_thr(rst_thr), .cmp_dis(cmp_dis),
    .hibernate(hibernate), .vr_clr(vr_clr), .ocv(ocv), .ocv_ready(ocv_ready),
    .soc_ready(soc_ready), .restart_pulse(restart_pulse), .vr_flag(vr_flag));

  always @(posedge clk) if (rst_n && restart_pulse) pulses <= pulses + 1;

  // {peak position, peak value, floor}; sample i = floor + i except at the peak
  localparam logic [28:0] VEC [5] = '{
    {5'd0,  12'hA00, 12'h100},
    {5'd15, 12'h800, 12'h200},
    {5'd7,  12'h050, 12'h300},
    {5'd3,  12'hFFF, 12'h000},
    {5'd9,  12'h000, 12'h000}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_with(input logic [11:0] v);
    @(negedge clk) sample = v; tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic qs_write(input logic d);
    @(negedge clk) qs_wr = 1'b1; qs_data = d;
    @(negedge clk) qs_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic vupd(input logic [11:0] v);
    @(negedge clk) vcell = v; vcell_upd = 1'b1;
    @(negedge clk) vcell_upd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    logic [11:0] expv, s;
    repeat (3) @(negedge clk);
    check("R1 ocv in reset", ocv, 0);
    check("R1 flags in reset", {ocv_ready, soc_ready, restart_pulse, vr_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 power-up restart", restart_pulse, 1);
    check("R11 flag on restart", vr_flag, 1);
    @(negedge clk);
    check("R12 single pulse", restart_pulse, 0);

    for (int e = 0; e < 5; e++) begin
      qs_write(1'b1);
      expv = '0;
      for (int i = 0; i < 16; i++) begin
        s = (i == int'(VEC[e][28:24])) ? VEC[e][23:12] : VEC[e][11:0] + 12'(i);
        if (s > expv) expv = s;
        tick_with(s);
      end
      check("R3 not ready after 16 ticks", ocv_ready, 0);
      check("R3 ocv zero while unready", ocv, 0);
      tick_with(12'hFFF);
      check("R3 ready on tick 17", ocv_ready, 1);
      check("R2 maximum of window", ocv, expv);
    end

    for (int i = 0; i < 174; i++) tick_with(12'h000);
    check("R4 soc not ready at 191", soc_ready, 0);
    tick_with(12'h000);
    check("R4 soc ready at 192", soc_ready, 1);

    qs_write(1'b1);
    for (int i = 0; i < 8; i++) tick_with(12'hFF0);
    qs_write(1'b1);
    for (int i = 0; i < 16; i++) tick_with(12'h100 + 12'(i));
    check("R7 old window abandoned", ocv_ready, 0);
    tick_with(12'hFFF);
    check("R7 fresh window ready", ocv_ready, 1);
    check("R7 fresh window maximum", ocv, 12'h10F);

    p0 = pulses;
    @(negedge clk) qs_pin = 1'b1;
    @(negedge clk);
    check("R12 pin pulse visible", restart_pulse, 1);
    check("R5 ready cleared", ocv_ready, 0);
    @(negedge clk);
    check("R12 pin pulse one cycle", restart_pulse, 0);
    repeat (5) @(negedge clk);
    check("R5 one restart per rise", pulses, p0 + 1);
    qs_pin = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 falling edge ignored", pulses, p0 + 1);

    p0 = pulses;
    qs_write(1'b0);
    repeat (3) @(negedge clk);
    check("R6 write of 0 ignored", pulses, p0);
    qs_write(1'b1);
    repeat (3) @(negedge clk);
    check("R6 write of 1 restarts once", pulses, p0 + 1);

    p0 = pulses;
    @(negedge clk) cmp_above = 1'b0;
    repeat (2) @(negedge clk);
    cmp_above = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 waits for tick", pulses, p0);
    tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R8 comparator swap restart", pulses, p0 + 1);

    cmp_dis = 1'b1;
    p0 = pulses;
    @(negedge clk) cmp_above = 1'b0;
    repeat (2) @(negedge clk);
    cmp_above = 1'b1;
    repeat (2) @(negedge clk);
    tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R10 disable outside hibernate", pulses, p0 + 1);

    hibernate = 1'b1;
    p0 = pulses;
    @(negedge clk) cmp_above = 1'b0;
    repeat (2) @(negedge clk);
    cmp_above = 1'b1;
    for (int i = 0; i < 3; i++) tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R9 comparator ignored", pulses, p0);
    vupd(12'h9FF);
    vupd(12'hA00);
    for (int i = 0; i < 249; i++) tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R9 no restart at 249", pulses, p0);
    tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R9 restart at 250", pulses, p0 + 1);

    p0 = pulses;
    vupd(12'h9FF);
    vupd(12'hA00);
    for (int i = 0; i < 100; i++) tick_with(12'h000);
    vupd(12'h9E0);
    for (int i = 0; i < 200; i++) tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R9 wait cancelled by drop", pulses, p0);
    vupd(12'hA40);
    for (int i = 0; i < 250; i++) tick_with(12'h000);
    repeat (2) @(negedge clk);
    check("R9 rearmed restart", pulses, p0 + 1);

    @(negedge clk) vr_clr = 1'b1;
    @(negedge clk) vr_clr = 1'b0;
    check("R11 flag cleared", vr_flag, 0);
    qs_write(1'b1);
    check("R11 flag set again", vr_flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule